// File: doc/BRIEF.md
# USB OTG Interrupt Aggregation Wrapper

This block gathers the interrupt events of a USB OTG controller core into one 32-bit pending register and presents them to the processor through a small register port with single-cycle access. Endpoint transmit events, endpoint receive events, core bus events and a VBUS-drive-change event each have their own field in the pending register. Software never does a read-modify-write on the pending bits or on the enable mask. It changes them only through dedicated write-one-to-set and write-one-to-clear addresses, so a hardware event can never be lost to a software update.

The block drives one level-sensitive interrupt line. The line stays high while any enabled event is pending. Once it has been raised, it stays low after it drops until software writes the end-of-interrupt address. This gives the interrupt handler a clean boundary between one service pass and the next. A revision register, a status register carrying the VBUS-drive level, and a control register with a self-clearing soft-reset bit complete the register map.

Top module: `usb_irq_wrap`

## Requirements
- R1: Address 0x00 reads a fixed nonzero revision value (parameter REVISION), and address 0x04 (control) always reads 0.
- R2: After reset, the pending register, the enable mask, the masked view and the interrupt line are all 0.
- R3: A write to 0x24 sets exactly those pending bits written as 1, and a write to 0x28 clears exactly those bits written as 1; all other bits keep their value. Reads of 0x20, 0x24 and 0x28 all return the current pending value.
- R4: A write to 0x30 sets, and a write to 0x34 clears, only the enable mask bits written as 1. Reads of 0x2C, 0x30 and 0x34 all return the mask. Address 0x38 reads the pending value ANDed with the mask, and a pending bit whose mask bit is 0 never raises the line.
- R5: Only bits 0-4 (transmit endpoints), 9-12 (receive endpoints), 16-23 (core events) and 24 (VBUS-drive change) exist, giving a valid-bit pattern of 0x01FF1E1F. All other bits read 0 even when written as 1. A one-cycle pulse on tx_evt[k], rx_evt[k], core_evt[k] or vbus_evt sets bit k, 9+k, 16+k or 24 respectively.
- R6: When an event pulse and a clear write hit the same bit in the same cycle, the bit stays pending. Other bits in the same clear write are cleared.
- R7: The interrupt line is a register. It rises one clock after the masked view becomes nonzero and stays high while the masked view stays nonzero.
- R8: Once the line has been high and has dropped, it stays low whatever becomes pending, until an end-of-interrupt write.
- R9: A write of any value to 0x3C forces the line low on that clock edge. On the next clock the line goes high if masked events are still pending.
- R10: Writing control (0x04) with bit 0 set clears the pending register, the mask and the end-of-interrupt state in one clock; a control write with bit 0 clear has no effect.
- R11: Address 0x08 reads the vbus_drive input in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| tx_evt | input | 5 | Transmit endpoint event pulses (endpoint 0 and four more) |
| rx_evt | input | 4 | Receive endpoint event pulses |
| core_evt | input | 8 | Core bus event pulses |
| vbus_evt | input | 1 | VBUS-drive-change event pulse |
| vbus_drive | input | 1 | Current VBUS-drive level, shown in the status register |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench walks a single 1 through all 32 bit positions of the set and clear ports, for both the pending register and the mask. This exposes any bit that should not exist but was given storage, and any write that disturbs bits written as 0. It pulses each event input on its own and checks that the bit lands at its computed position. A wrong field offset shows up as a bit at the wrong place. It drives a clear write and an event on the same bit in one cycle; a design that gives the clear priority loses that event. The interrupt line is checked cycle by cycle around the first raise, around a drop followed by new events, and around end-of-interrupt writes made while the line is low and while it is high. A design without the end-of-interrupt hold would re-raise early, and one that waits an extra cycle or forgets to re-arm would miss the expected rise. Soft reset is checked with the line held off, so it must re-arm the line as well as clear the pending bits and the mask.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFF_REV     = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RAW     = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RAW_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_RAW_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_MSK     = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_MSK_SET = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_MSK_CLR = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_MASKED  = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_EOI     = 8'h3C;

  // event field placement inside the pending word
  localparam int TX_N     = 5;
  localparam int TX_LSB   = 0;
  localparam int RX_N     = 4;
  localparam int RX_LSB   = 9;
  localparam int CORE_N   = 8;
  localparam int CORE_LSB = 16;
  localparam int VBUS_BIT = 24;

  function automatic logic [DATA_W-1:0] valid_bits();
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < TX_N; i++)   v[TX_LSB + i]   = 1'b1;
    for (int i = 0; i < RX_N; i++)   v[RX_LSB + i]   = 1'b1;
    for (int i = 0; i < CORE_N; i++) v[CORE_LSB + i] = 1'b1;
    v[VBUS_BIT] = 1'b1;
    return v;
  endfunction

  typedef struct packed {
    logic raw_set;
    logic raw_clr;
    logic msk_set;
    logic msk_clr;
    logic eoi;
    logic soft_rst;
  } wr_strobe_t;

endpackage

// File: rtl/usb_irq_src.sv
module usb_irq_src #(
  parameter int              W     = 32,
  parameter logic [W-1:0]    VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] src_q
);

  logic unused_src_bits;
  assign unused_src_bits = ^(wdata & ~VALID) ^ ^(evt & ~VALID);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_cell
      logic q;
      logic nxt;
      logic ce;

      assign ce = set_we | clr_we | evt[i] | soft_rst;

      always_comb begin
        nxt = q;
        if (set_we && wdata[i]) nxt = 1'b1;
        if (clr_we && wdata[i]) nxt = 1'b0;
        if (evt[i])             nxt = 1'b1;   // hardware event beats a clear
        if (soft_rst)           nxt = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (ce) q <= nxt;
      end

      assign src_q[i] = q;
    end else begin : g_none
      assign src_q[i] = 1'b0;
    end
  end

  // R6: an event pulse always leaves its bit pending
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((src_q & $past(evt & VALID)) == $past(evt & VALID)));

  // R3: a clear write with no competing event or set removes the bits
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !soft_rst) |=> ((src_q & $past(wdata & ~evt)) == '0));

  // R3: bits not touched by any write or event keep their value
  a_r3_hold_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !set_we && !clr_we && (evt == '0)) |=> $stable(src_q));

  // R10: soft reset empties the pending register
  a_r10_src_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (src_q == '0));

endmodule

// File: rtl/usb_irq_mask.sv
module usb_irq_mask #(
  parameter int           W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;
  logic         mask_ce;

  assign mask_ce = set_we | clr_we | soft_rst;

  always_comb begin
    mask_d = mask_q;
    if (set_we) mask_d = mask_d | (wdata & VALID);
    if (clr_we) mask_d = mask_d & ~wdata;
    if (soft_rst) mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  // R4: set port turns on exactly the written valid bits
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !soft_rst) |=> ((mask_q & $past(wdata & VALID)) == $past(wdata & VALID)));

  // R4: clear port turns off the written bits
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !soft_rst) |=> ((mask_q & $past(wdata)) == '0));

  // R10: soft reset empties the mask
  a_r10_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask_q == '0));

endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic eoi_wr,
  input  logic pend,
  output logic irq
);

  logic irq_q, irq_d;
  logic fired_q, fired_d;

  always_comb begin
    irq_d   = irq_q;
    fired_d = fired_q;
    if (soft_rst || eoi_wr) begin
      irq_d   = 1'b0;
      fired_d = 1'b0;
    end else begin
      irq_d   = irq_q ? pend : (pend && !fired_q);
      fired_d = fired_q | irq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      irq_q   <= irq_d;
      fired_q <= fired_d;
    end
  end

  assign irq = irq_q;

  // R7: the line is only ever high when something enabled was pending
  a_r7_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(pend));

  // R8: after a drop the line stays low until an end-of-interrupt
  a_r8_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !irq_q && !eoi_wr && !soft_rst) |=> !irq_q);

  // R9: an end-of-interrupt or soft reset drops the line
  a_r9_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr || soft_rst) |=> !irq_q);

endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap #(
  parameter logic [31:0] REVISION = 32'h0002_0A01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [4:0]  tx_evt,
  input  logic [3:0]  rx_evt,
  input  logic [7:0]  core_evt,
  input  logic        vbus_evt,
  input  logic        vbus_drive,
  output logic        irq
);
  import usb_irq_pkg::*;

  localparam logic [DATA_W-1:0] VALID = valid_bits();

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // write decode
  wr_strobe_t stb;

  always_comb begin
    stb          = '0;
    stb.raw_set  = bus_we && (bus_addr == OFF_RAW_SET);
    stb.raw_clr  = bus_we && (bus_addr == OFF_RAW_CLR);
    stb.msk_set  = bus_we && (bus_addr == OFF_MSK_SET);
    stb.msk_clr  = bus_we && (bus_addr == OFF_MSK_CLR);
    stb.eoi      = bus_we && (bus_addr == OFF_EOI);
    stb.soft_rst = bus_we && (bus_addr == OFF_CTRL) && bus_wdata[0];
  end

  // place event lines into the pending word
  logic [DATA_W-1:0] evt_vec;

  always_comb begin
    evt_vec                       = '0;
    evt_vec[TX_LSB +: TX_N]       = tx_evt;
    evt_vec[RX_LSB +: RX_N]       = rx_evt;
    evt_vec[CORE_LSB +: CORE_N]   = core_evt;
    evt_vec[VBUS_BIT]             = vbus_evt;
  end

  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] masked;
  logic              pend;

  usb_irq_src #(.W(DATA_W), .VALID(VALID)) i_src (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (stb.soft_rst),
    .set_we   (stb.raw_set),
    .clr_we   (stb.raw_clr),
    .wdata    (bus_wdata),
    .evt      (evt_vec),
    .src_q    (src_q)
  );

  usb_irq_mask #(.W(DATA_W), .VALID(VALID)) i_mask (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (stb.soft_rst),
    .set_we   (stb.msk_set),
    .clr_we   (stb.msk_clr),
    .wdata    (bus_wdata),
    .mask_q   (mask_q)
  );

  assign masked = src_q & mask_q;
  assign pend   = |masked;

  usb_irq_gate i_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (stb.soft_rst),
    .eoi_wr   (stb.eoi),
    .pend     (pend),
    .irq      (irq)
  );

  // read mux
  always_comb begin
    case (bus_addr)
      OFF_REV:                          bus_rdata = REVISION;
      OFF_STAT:                         bus_rdata = {{(DATA_W-1){1'b0}}, vbus_drive};
      OFF_RAW, OFF_RAW_SET, OFF_RAW_CLR: bus_rdata = src_q;
      OFF_MSK, OFF_MSK_SET, OFF_MSK_CLR: bus_rdata = mask_q;
      OFF_MASKED:                       bus_rdata = masked;
      default:                          bus_rdata = '0;
    endcase
  end

  // R1: the revision value is never zero
  a_r1_rev_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == OFF_REV) |-> (bus_rdata != '0));

  // R5: nonexistent pending bits never appear
  a_r5_no_ghost_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q & ~VALID) == '0);

endmodule

// File: tb/test_usb_irq_wrap.sv
`timescale 1ns/1ps
module test_usb_irq_wrap;

  localparam logic [31:0] REV   = 32'h0002_0A01;
  localparam logic [31:0] VALID = 32'h0000_001F | (32'hF << 9) | (32'hFF << 16) | (32'h1 << 24);
  localparam logic [7:0] A_REV = 8'h00, A_CTRL = 8'h04, A_STAT = 8'h08;
  localparam logic [7:0] A_RAW = 8'h20, A_RSET = 8'h24, A_RCLR = 8'h28;
  localparam logic [7:0] A_MSK = 8'h2C, A_MSET = 8'h30, A_MCLR = 8'h34;
  localparam logic [7:0] A_MASKED = 8'h38, A_EOI = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [4:0]  tx_evt;
  logic [3:0]  rx_evt;
  logic [7:0]  core_evt;
  logic        vbus_evt;
  logic        vbus_drive;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  usb_irq_wrap #(.REVISION(REV)) i_usb_irq_wrap (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .core_evt(core_evt), .vbus_evt(vbus_evt),
    .vbus_drive(vbus_drive), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_evt(input int k);
    @(negedge clk);
    if (k < 5)       tx_evt[k] = 1'b1;
    else if (k < 9)  rx_evt[k-5] = 1'b1;
    else if (k < 17) core_evt[k-9] = 1'b1;
    else             vbus_evt = 1'b1;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; core_evt = '0; vbus_evt = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pat_a, pat_b;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_evt = '0; rx_evt = '0; core_evt = '0; vbus_evt = 1'b0; vbus_drive = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R2 reset state, R1 fixed registers
    chk("R2 raw after reset", 32'(0), 32'(0));
    chk_rd("R2 raw after reset", A_RAW, 32'h0);
    chk_rd("R2 mask after reset", A_MSK, 32'h0);
    chk_rd("R2 masked after reset", A_MASKED, 32'h0);
    chk("R2 irq after reset", {31'b0, irq}, 32'h0);
    chk_rd("R1 revision", A_REV, REV);
    chk("R1 revision nonzero", {31'b0, (REV != 0)}, 32'h1);
    chk_rd("R1 control reads 0", A_CTRL, 32'h0);

    // R3 / R5: walk a single 1 through the pending register
    for (int i = 0; i < 32; i++) begin
      wr(A_RSET, 32'h1 << i);
      chk_rd("R5 raw single bit", A_RAW, (32'h1 << i) & VALID);
      chk_rd("R3 set port reads raw", A_RSET, (32'h1 << i) & VALID);
      chk_rd("R3 clr port reads raw", A_RCLR, (32'h1 << i) & VALID);
      wr(A_RCLR, 32'h1 << i);
      chk_rd("R3 raw cleared", A_RAW, 32'h0);
    end

    // R3: only bits written as 1 change
    wr(A_RSET, 32'h0000_0003);
    wr(A_RSET, 32'h0001_0004);
    chk_rd("R3 set accumulates", A_RAW, 32'h0001_0007);
    wr(A_RCLR, 32'h0000_0002);
    chk_rd("R3 clear selective", A_RAW, 32'h0001_0005);
    wr(A_RCLR, 32'hFFFF_FFFF);
    chk_rd("R3 clear all", A_RAW, 32'h0);

    // R4: walk the mask and check the masked view
    for (int i = 0; i < 32; i++) begin
      wr(A_MSET, 32'h1 << i);
      chk_rd("R4 mask single bit", A_MSK, (32'h1 << i) & VALID);
      chk_rd("R4 mset port reads mask", A_MSET, (32'h1 << i) & VALID);
      chk_rd("R4 mclr port reads mask", A_MCLR, (32'h1 << i) & VALID);
      wr(A_MCLR, 32'h1 << i);
      chk_rd("R4 mask cleared", A_MSK, 32'h0);
    end
    for (int p = 0; p < 4; p++) begin
      pat_a = (32'hA5A5_5A5A >> p) ^ (32'h0F0F_3C3C << p);
      pat_b = (32'h3333_CCCC << p) ^ (32'hFFFF_0000 >> p);
      wr(A_RSET, pat_a);
      wr(A_MSET, pat_b);
      chk_rd("R4 masked view", A_MASKED, pat_a & pat_b & VALID);
      wr(A_RCLR, 32'hFFFF_FFFF);
      wr(A_MCLR, 32'hFFFF_FFFF);
    end

    // R5: each event input lands at its computed position
    for (int k = 0; k < 18; k++) begin
      int pos;
      if (k < 5)       pos = k;
      else if (k < 9)  pos = 9 + (k - 5);
      else if (k < 17) pos = 16 + (k - 9);
      else             pos = 24;
      pulse_evt(k);
      chk_rd("R5 event position", A_RAW, 32'h1 << pos);
      wr(A_RCLR, 32'hFFFF_FFFF);
    end

    // R6: event beats a clear on the same bit
    wr(A_RSET, 32'h0000_0201);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_RCLR; bus_wdata = 32'h0000_0201; rx_evt[0] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; rx_evt = '0;
    chk_rd("R6 event wins over clear", A_RAW, 32'h0000_0200);
    wr(A_RCLR, 32'hFFFF_FFFF);

    // clean interrupt state
    wr(A_MCLR, 32'hFFFF_FFFF);
    wr(A_EOI, 32'h0);
    idle(2);

    // R4: masked-off source does not raise the line
    wr(A_RSET, 32'h1 << 24);
    idle(3);
    chk("R4 masked-off no irq", {31'b0, irq}, 32'h0);

    // R7: rise one cycle after enable, level while pending
    wr(A_MSET, 32'h1 << 24);
    chk("R7 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    idle(3);
    chk("R7 irq held", {31'b0, irq}, 32'h1);
    wr(A_MSET, 32'hFFFF_FFFF);
    wr(A_RCLR, 32'hFFFF_FFFF);
    chk("R7 irq one cycle late", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);

    // R8: new events while waiting for end-of-interrupt
    wr(A_RSET, 32'h1 << 3);
    idle(4);
    chk("R8 held off", {31'b0, irq}, 32'h0);
    pulse_evt(12);
    idle(2);
    chk("R8 held off after event", {31'b0, irq}, 32'h0);

    // R9: end-of-interrupt with any value re-arms
    wr(A_EOI, 32'hDEAD_BEEF);
    chk("R9 irq low at eoi", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq re-raised", {31'b0, irq}, 32'h1);
    wr(A_EOI, 32'h0);
    chk("R9 eoi while high drops", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 eoi while high re-raise", {31'b0, irq}, 32'h1);

    // R10: soft reset while held off
    wr(A_RCLR, 32'hFFFF_FFFF);
    idle(2);
    wr(A_RSET, 32'h1);
    idle(2);
    chk("R10 held off before reset", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFE);
    chk_rd("R10 ctrl bit0 clear no effect raw", A_RAW, 32'h1);
    chk_rd("R10 ctrl bit0 clear no effect mask", A_MSK, VALID);
    wr(A_CTRL, 32'h1);
    chk_rd("R10 raw cleared", A_RAW, 32'h0);
    chk_rd("R10 mask cleared", A_MSK, 32'h0);
    chk_rd("R10 control reads 0", A_CTRL, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    wr(A_MSET, 32'h1);
    wr(A_RSET, 32'h1);
    @(negedge clk);
    chk("R10 re-armed without eoi", {31'b0, irq}, 32'h1);

    // R11: status register
    vbus_drive = 1'b1;
    chk_rd("R11 status high", A_STAT, 32'h1);
    vbus_drive = 1'b0;
    chk_rd("R11 status low", A_STAT, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule